// File: doc/BRIEF.md
# Two-Point Signature Resistance Classifier

This block decides what is attached to a powered-Ethernet port at the end of a detection cycle. It receives two averaged measurement points, each a port voltage and a probe current, and works out the slope resistance as the voltage step divided by the current step. Any constant offset in voltage or current therefore drops out. The slope is compared against fixed resistance limits by cross-multiplication, so no divider is needed. The block then reports one of eight category codes and a flag that is set only for an acceptable powered device.

The port-voltage range and the probe-step rule are checked before the slope. An external measurement path supplies two capacitance flags. A configuration input chooses which of the two flags counts as a high-capacitance load: the one for the normal limit, or the one for the larger legacy limit (up to 150 µF).

Everything ahead of the output stage is combinational. The result is captured when a start strobe is seen and is held until the next strobe.

Top module: `sig_slope_classifier`

## Requirements
- R1: After a synchronous active-low reset, `cat_o` reads 0 (invalid) and `pd_ok_o` reads 0.
- R2: `cat_o` and `pd_ok_o` change only on the clock edge that follows a cycle with `start_i` high. In every other cycle they keep their value, whatever the other inputs do.
- R3: A slope resistance from 19.0 kΩ to 26.5 kΩ, both ends included, gives code 1 (valid device) with `pd_ok_o` = 1. Every other code gives `pd_ok_o` = 0.
- R4: A slope resistance below 19.0 kΩ gives code 3 (low resistance). This includes the undefined band from 15 kΩ to 19 kΩ.
- R5: A slope resistance above 26.5 kΩ and up to 500 kΩ, with 500 kΩ included, gives code 4 (high resistance). This includes the undefined band from 26.5 kΩ to 33 kΩ.
- R6: A slope resistance above 500 kΩ gives code 2 (open circuit).
- R7: When both voltages are in range and the two voltages differ by less than 1.000 V (1000 LSB), the result is code 0 (invalid measurement). The two points may arrive in either order; only the size of the step counts.
- R8: A supply fault takes priority over every other result. If either voltage is above 10.000 V, the result is code 6 (positive supply). Otherwise, if either voltage is below 2.800 V, the result is code 7 (negative supply).
- R9: When the voltage step is valid, the current step is taken in the same direction as the voltage step. If that current step is zero or negative, the result is code 6.
- R10: If neither R8, R7 nor R9 applies, the selected capacitance flag gives code 5 (high capacitance). The selected flag is `cap_big_over_i` when `legacy_cap_en_i` = 1, and `cap_std_over_i` when it is 0.
- R11: Adding the same offset to both currents leaves the result unchanged.

Units: 1 voltage LSB = 1 mV. 1 current LSB = 10 nA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Capture strobe for the result |
| volt_a_i | input | 16 | Port voltage at first probe point, mV |
| volt_b_i | input | 16 | Port voltage at second probe point, mV |
| curr_a_i | input | 16 | Probe current at first point, 10 nA units |
| curr_b_i | input | 16 | Probe current at second point, 10 nA units |
| cap_std_over_i | input | 1 | Load capacitance exceeds the normal limit |
| cap_big_over_i | input | 1 | Load capacitance exceeds the legacy limit |
| legacy_cap_en_i | input | 1 | Selects the legacy capacitance limit |
| cat_o | output | 3 | Category code |
| pd_ok_o | output | 1 | Valid powered device found |

## Verification
The bench aims at the edges of each resistance window, computed exactly:
- 19.00 kΩ and 18.99 kΩ;
- 26.50 kΩ and just above it;
- exactly 500 kΩ and just above it.

A comparison written with the wrong strictness would move one of these points into the neighbouring code.

Other directed cases cover:
- a 0.999 V step against a 1.000 V step;
- reversed probe order;
- a zero current step;
- a current offset common to both points;
- each side of the supply voltage range;
- both settings of the capacitance selection.

A wrong priority among these tests would report, for example, a high-capacitance code for a load that is really a supply.

Random vectors then sweep the resistance across its whole range. Further vectors change the inputs without a strobe to show that the result is held.

// File: rtl/sig_cls_pkg.sv
// Package: shared category encoding for the slope classifier.
// Assumes 3-bit codes; the values are visible at the block's output port.
package sig_cls_pkg;
    typedef enum logic [2:0] {
        CAT_INVALID  = 3'd0,
        CAT_VALID    = 3'd1,
        CAT_OPEN     = 3'd2,
        CAT_LOW_R    = 3'd3,
        CAT_HIGH_R   = 3'd4,
        CAT_HIGH_CAP = 3'd5,
        CAT_POS_SUP  = 3'd6,
        CAT_NEG_SUP  = 3'd7
    } sig_cat_e;
endpackage

// File: rtl/sig_delta.sv
// sig_delta: forms the voltage and current steps between the two probe points.
// The voltage step is made positive; the current step is given the same orientation.
// It also flags port voltages outside the allowed probe range.
// Assumes unsigned inputs.
module sig_delta #(
    parameter int VW    = 16,
    parameter int IW    = 16,
    parameter int V_MIN = 2800,
    parameter int V_MAX = 10000
) (
    input  logic [VW-1:0] va,
    input  logic [VW-1:0] vb,
    input  logic [IW-1:0] ia,
    input  logic [IW-1:0] ib,
    output logic [VW-1:0] dv_mag,
    output logic [IW-1:0] di_mag,
    output logic          di_pos,
    output logic          v_high,
    output logic          v_low
);
    logic signed [VW:0] dv, dv_neg;
    logic signed [IW:0] di, di_ori;

    // Signed steps, then orient both so that the voltage step is positive.
    always_comb begin
        dv     = $signed({1'b0, vb}) - $signed({1'b0, va});
        dv_neg = -dv;
        di     = $signed({1'b0, ib}) - $signed({1'b0, ia});
        di_ori = dv[VW] ? -di : di;
        dv_mag = dv[VW] ? dv_neg[VW-1:0] : dv[VW-1:0];
        di_mag = di_ori[IW-1:0];
        di_pos = !di_ori[IW] && (di_ori != '0);
    end

    // Probe range check on both voltages.
    always_comb begin
        v_high = (va > VW'(V_MAX)) || (vb > VW'(V_MAX));
        v_low  = (va < VW'(V_MIN)) || (vb < VW'(V_MIN));
    end
endmodule

// File: rtl/sig_ratio_cmp.sv
// sig_ratio_cmp: compares dv/di against a threshold with no divider.
// Test: dv*SCALE against di*THR.
// Assumes di > 0 when the result is used; SCALE and THR fit in TW bits.
module sig_ratio_cmp #(
    parameter int VW    = 16,
    parameter int IW    = 16,
    parameter int TW    = 16,
    parameter int SCALE = 1000,
    parameter int THR   = 190
) (
    input  logic [VW-1:0] dv_mag,
    input  logic [IW-1:0] di_mag,
    output logic          above,
    output logic          below
);
    localparam int PW = ((VW > IW) ? VW : IW) + TW + 1;
    logic [PW-1:0] lhs, rhs;

    // Cross products, then strict comparisons in both directions.
    always_comb begin
        lhs   = PW'(dv_mag) * PW'(SCALE);
        rhs   = PW'(di_mag) * PW'(THR);
        above = lhs > rhs;
        below = lhs < rhs;
    end
endmodule

// File: rtl/sig_decide.sv
// sig_decide: priority resolution from the measurement flags to a category.
// Order, first match wins:
//   supply range, step too small, current slope not positive,
//   capacitance, then resistance.
module sig_decide
    import sig_cls_pkg::*;
(
    input  logic     v_high,
    input  logic     v_low,
    input  logic     step_small,
    input  logic     di_pos,
    input  logic     cap_over,
    input  logic     r_below_acc,
    input  logic     r_above_acc,
    input  logic     r_above_open,
    output sig_cat_e cat
);
    // Fixed-priority category selection.
    always_comb begin
        if (v_high)            cat = CAT_POS_SUP;
        else if (v_low)        cat = CAT_NEG_SUP;
        else if (step_small)   cat = CAT_INVALID;
        else if (!di_pos)      cat = CAT_POS_SUP;
        else if (cap_over)     cat = CAT_HIGH_CAP;
        else if (r_above_open) cat = CAT_OPEN;
        else if (r_above_acc)  cat = CAT_HIGH_R;
        else if (r_below_acc)  cat = CAT_LOW_R;
        else                   cat = CAT_VALID;
    end
endmodule

// File: rtl/sig_slope_classifier.sv
// sig_slope_classifier: top level.
// Steps, cross-multiplied resistance tests and priority decision,
// with the result captured on start_i.
// Resistance thresholds are in 100-ohm units. SCALE makes them line up with
// mV / 10 nA (1 unit = 100 kOhm), so R[100 Ohm] = dv*1000/di.
// Synchronous active-low reset.
module sig_slope_classifier
    import sig_cls_pkg::*;
#(
    parameter int VW       = 16,
    parameter int IW       = 16,
    parameter int TW       = 16,
    parameter int SCALE    = 1000,
    parameter int R_ACC_LO = 190,
    parameter int R_ACC_HI = 265,
    parameter int R_OPEN   = 5000,
    parameter int DV_MIN   = 1000,
    parameter int V_MIN    = 2800,
    parameter int V_MAX    = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [VW-1:0] volt_a_i,
    input  logic [VW-1:0] volt_b_i,
    input  logic [IW-1:0] curr_a_i,
    input  logic [IW-1:0] curr_b_i,
    input  logic          cap_std_over_i,
    input  logic          cap_big_over_i,
    input  logic          legacy_cap_en_i,
    output logic [2:0]    cat_o,
    output logic          pd_ok_o
);
    localparam int NTHR = 3;
    localparam int THR_LIST [NTHR] = '{R_ACC_LO, R_ACC_HI, R_OPEN};

    logic [VW-1:0]   dv_mag;
    logic [IW-1:0]   di_mag;
    logic            di_pos, v_high, v_low, step_small, cap_over;
    logic [NTHR-1:0] thr_above, thr_below;
    sig_cat_e        cat_next;

    sig_delta #(.VW(VW), .IW(IW), .V_MIN(V_MIN), .V_MAX(V_MAX)) u_delta (
        .va(volt_a_i), .vb(volt_b_i), .ia(curr_a_i), .ib(curr_b_i),
        .dv_mag(dv_mag), .di_mag(di_mag), .di_pos(di_pos),
        .v_high(v_high), .v_low(v_low)
    );

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        sig_ratio_cmp #(.VW(VW), .IW(IW), .TW(TW), .SCALE(SCALE), .THR(THR_LIST[g])) u_cmp (
            .dv_mag(dv_mag), .di_mag(di_mag),
            .above(thr_above[g]), .below(thr_below[g])
        );
    end

    // Step-size rule and capacitance limit selection.
    always_comb begin
        step_small = dv_mag < VW'(DV_MIN);
        cap_over   = legacy_cap_en_i ? cap_big_over_i : cap_std_over_i;
    end

    sig_decide u_decide (
        .v_high(v_high), .v_low(v_low), .step_small(step_small), .di_pos(di_pos),
        .cap_over(cap_over), .r_below_acc(thr_below[0]), .r_above_acc(thr_above[1]),
        .r_above_open(thr_above[2]), .cat(cat_next)
    );

    // Result register: loads on start_i, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cat_o   <= CAT_INVALID;
            pd_ok_o <= 1'b0;
        end else if (start_i) begin
            cat_o   <= cat_next;
            pd_ok_o <= (cat_next == CAT_VALID);
        end
    end
endmodule

// File: rtl/sig_slope_classifier_chk.sv
// sig_slope_classifier_chk: property checker.
// Attached to the top by bind; it reads only the top's ports.
module sig_slope_classifier_chk #(
    parameter int VW     = 16,
    parameter int DV_MIN = 1000,
    parameter int V_MIN  = 2800,
    parameter int V_MAX  = 10000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [VW-1:0] volt_a_i,
    input logic [VW-1:0] volt_b_i,
    input logic [2:0]    cat_o,
    input logic          pd_ok_o
);
    logic hi_in, lo_in, small_in;

    // Independent range and step evaluation from the port values.
    always_comb begin
        hi_in    = (int'(volt_a_i) > V_MAX) || (int'(volt_b_i) > V_MAX);
        lo_in    = (int'(volt_a_i) < V_MIN) || (int'(volt_b_i) < V_MIN);
        small_in = ((int'(volt_a_i) - int'(volt_b_i)) < DV_MIN) &&
                   ((int'(volt_b_i) - int'(volt_a_i)) < DV_MIN);
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(cat_o) && $stable(pd_ok_o)));

    p_flag_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (pd_ok_o == (cat_o == 3'd1)));

    p_small_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !hi_in && !lo_in && small_in) |=> (cat_o == 3'd0));

    p_pos_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && hi_in) |=> (cat_o == 3'd6 && !pd_ok_o));

    p_neg_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !hi_in && lo_in) |=> (cat_o == 3'd7 && !pd_ok_o));
endmodule

bind sig_slope_classifier sig_slope_classifier_chk #(
    .VW(VW), .DV_MIN(DV_MIN), .V_MIN(V_MIN), .V_MAX(V_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .volt_a_i(volt_a_i), .volt_b_i(volt_b_i),
    .cat_o(cat_o), .pd_ok_o(pd_ok_o)
);

// File: tb/sig_slope_classifier_test.sv
// Bench: directed corners plus seeded random vectors.
// Expected codes come from a reference function written from the requirements.
module sig_slope_classifier_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] volt_a_i = '0, volt_b_i = '0, curr_a_i = '0, curr_b_i = '0;
    logic        cap_std_over_i = 1'b0, cap_big_over_i = 1'b0, legacy_cap_en_i = 1'b0;
    logic [2:0]  cat_o;
    logic        pd_ok_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sig_slope_classifier uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .volt_a_i(volt_a_i), .volt_b_i(volt_b_i),
        .curr_a_i(curr_a_i), .curr_b_i(curr_b_i),
        .cap_std_over_i(cap_std_over_i), .cap_big_over_i(cap_big_over_i),
        .legacy_cap_en_i(legacy_cap_en_i),
        .cat_o(cat_o), .pd_ok_o(pd_ok_o)
    );

    // Reference model, written from R3-R10.
    function automatic int ref_cat(int va, int vb, int ia, int ib, bit cs, bit cb, bit leg);
        longint dv, di, lhs;
        dv = vb - va;
        di = ib - ia;
        if (va > 10000 || vb > 10000) return 6;          // R8
        if (va < 2800 || vb < 2800) return 7;            // R8
        if (dv < 0) begin dv = -dv; di = -di; end
        if (dv < 1000) return 0;                         // R7
        if (di <= 0) return 6;                           // R9
        if (leg ? cb : cs) return 5;                     // R10
        lhs = dv * 1000;
        if (lhs > di * 5000) return 2;                   // R6
        if (lhs > di * 265) return 4;                    // R5
        if (lhs < di * 190) return 3;                    // R4
        return 1;                                        // R3
    endfunction

    function automatic string tag_of(int c);
        case (c)
            0: return "R7";
            1: return "R3";
            2: return "R6";
            3: return "R4";
            4: return "R5";
            5: return "R10";
            6: return "R8/R9";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, int exp_c);
        n_vec++;
        if (int'(cat_o) != exp_c || pd_ok_o != (exp_c == 1)) begin
            n_bad++;
            $display("FAIL %s: cat=%0d pd_ok=%0d expected cat=%0d pd_ok=%0d",
                     req, cat_o, pd_ok_o, exp_c, (exp_c == 1));
        end
    endtask

    // Drive one vector with a strobe, then sample one negedge after the capture edge.
    task automatic apply(int va, int vb, int ia, int ib, bit cs, bit cb, bit leg, string req);
        int e;
        @(negedge clk);
        volt_a_i = 16'(va); volt_b_i = 16'(vb);
        curr_a_i = 16'(ia); curr_b_i = 16'(ib);
        cap_std_over_i = cs; cap_big_over_i = cb; legacy_cap_en_i = leg;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        e = ref_cat(va, vb, ia, ib, cs, cb, leg);
        check((req == "") ? tag_of(e) : req, e);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int e_keep;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        check("R1", 0);                                  // reset state
        rst_n = 1'b1;

        apply(3000, 4900, 1000, 11000, 0, 0, 0, "R3 19.00k edge");
        apply(3000, 4899, 1000, 11000, 0, 0, 0, "R4 18.99k");
        apply(3000, 5650, 2000, 12000, 0, 0, 0, "R3 26.50k edge");
        apply(3000, 5651, 2000, 12000, 0, 0, 0, "R5 26.51k");
        apply(3000, 4700, 500, 10500, 0, 0, 0, "R4 17k reject band");
        apply(3000, 6000, 100, 10100, 0, 0, 0, "R5 30k reject band");
        apply(3000, 8000, 1000, 2000, 0, 0, 0, "R5 500k edge");
        apply(3000, 8000, 1000, 1999, 0, 0, 0, "R6 open");
        apply(4000, 4999, 1000, 11000, 0, 0, 0, "R7 0.999V step");
        apply(4000, 5000, 1000, 5000, 0, 0, 0, "R7 1.000V step ok");
        apply(4900, 3000, 11000, 1000, 0, 0, 0, "R7 reversed order");
        apply(3000, 5000, 5000, 5000, 0, 0, 0, "R9 zero current step");
        apply(3000, 5000, 9000, 1000, 0, 0, 0, "R9 negative current step");
        apply(3000, 10001, 1000, 30000, 0, 0, 0, "R8 above range");
        apply(2799, 4800, 1000, 11000, 1, 1, 0, "R8 below range");
        apply(3000, 4900, 1000, 11000, 1, 0, 0, "R10 std limit");
        apply(3000, 4900, 1000, 11000, 1, 0, 1, "R10 legacy ignores std flag");
        apply(3000, 4900, 1000, 11000, 0, 1, 1, "R10 legacy flag");
        apply(3000, 4900, 30000, 40000, 0, 0, 0, "R11 current offset");

        // R2: change inputs without a strobe; the output must not move.
        apply(3000, 4900, 1000, 11000, 0, 0, 0, "R2 setup");
        e_keep = 1;
        @(negedge clk);
        volt_a_i = 16'd12000; curr_b_i = 16'd0; cap_std_over_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 hold", e_keep);

        for (int k = 0; k < 600; k++) begin
            int va, vb, ia, ib, dv, di, r, t;
            bit cs, cb, leg;
            t  = $urandom_range(0, 9);
            va = $urandom_range(2800, 5000);
            dv = $urandom_range(0, 5000);
            vb = va + dv;
            r  = $urandom_range(100, 6500);
            di = (dv * 1000) / r + $urandom_range(0, 2);
            ia = $urandom_range(0, 10000);
            ib = ia + di;
            cs = ($urandom_range(0, 9) == 0);
            cb = ($urandom_range(0, 9) == 0);
            leg = $urandom_range(0, 1);
            if (t == 0) vb = $urandom_range(0, 20000);
            if (t == 1) ib = $urandom_range(0, 60000);
            if (t == 2) begin int s = va; va = vb; vb = s; s = ia; ia = ib; ib = s; end
            if (ib > 65535) ib = 65535;
            apply(va, vb, ia, ib, cs, cb, leg, "");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule